// File: doc/BRIEF.md
# Privilege and Fetch Protection Checker

This block watches every memory access a processor core issues and decides whether it is allowed. It holds a table of up to eight address regions. Each region has a base address, a power-of-two size and four permission flags. An access carries two qualifiers: a privilege flag (user or privileged) and a fetch flag (instruction fetch or data access). The block looks up the region that matches the address and combines these two qualifiers with the region's flags. This makes it possible to build supervisor-only regions, execute-only code regions and write-protected regions.

The verdict is registered. It appears on the abort output in the cycle after the access is sampled, so it lines up with the returned read data at the end of the access. A second bit, registered with the abort, tells the core whether to take a prefetch abort or a data abort. Region entries are loaded through a simple one-cycle write port. The block also drives the inverted low five bits of the core's status word for use by outside logic.

Top module: `prot_check`

## Requirements
- R1: While reset is asserted and after it is released, every region is disabled and both `abort` and `abort_pf` are 0.
- R2: When `cfg_we` is 1 at a rising edge, entry `cfg_idx` takes `cfg_base`, `cfg_size` and `cfg_perm`. The new entry applies to accesses sampled at later edges. An access sampled at that same edge is still judged against the old entry.
- R3: A size code k covers 2^(12+k) bytes, aligned to that size, so the address bits below 12+k are ignored in the match. Any code of 20 or more covers the whole 32-bit space.
- R4: `cfg_perm` bit 0 is enable. Among the enabled entries that match, the lowest-numbered one alone decides the verdict. An access that matches no enabled entry is aborted.
- R5: Only cycles with `acc_req` = 1 are checked. The verdict for an access sampled at edge N is shown on `abort` from edge N until edge N+1. A cycle with `acc_req` = 0 gives `abort` = 0.
- R6: `cfg_perm` bit 3 (privileged only) aborts any access made with `acc_priv` = 0.
- R7: `cfg_perm` bit 2 (execute only) aborts every data access (`acc_fetch` = 0), whether read or write. Fetches are allowed.
- R8: `cfg_perm` bit 1 (read only) aborts any access with `acc_write` = 1.
- R9: `abort_pf` is registered with `abort`. It equals the `acc_fetch` of the aborted access (1 = prefetch abort, 0 = data abort), and it is 0 whenever `abort` is 0.
- R10: `mode_inv` is always the bitwise inverse of `sr_mode`, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load one region entry |
| cfg_idx | input | 3 | Entry number to load |
| cfg_base | input | 32 | Region base address |
| cfg_size | input | 5 | Size code k, giving 2^(12+k) bytes |
| cfg_perm | input | 4 | {priv_only, exec_only, read_only, enable} |
| acc_req | input | 1 | Cycle needs a memory access |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged, 0 = user |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| sr_mode | input | 5 | Low five bits of the core status word |
| abort | output | 1 | Access denied, valid at the end of the access |
| abort_pf | output | 1 | Abort class: 1 = prefetch, 0 = data |
| mode_inv | output | 5 | Inverted `sr_mode` |

## Verification
The hardest situation to reach is overlapping enabled regions that give different verdicts, so that the outcome depends on priority. Alongside it sits a region write landing on the same edge as an access to that region. Random address traffic seldom lines up with both conditions at once. The stimulus therefore sets up directed overlaps: a small read-only region inside a larger open one, in both index orders. It also issues an access in the very cycle its region is rewritten. Random traffic then follows, with addresses drawn near the configured bases so that matches are frequent.

// File: rtl/prot_check.sv
module prot_check #(
  parameter int NREG   = 8,
  parameter int AW     = 32,
  parameter int MINLOG = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [$clog2(NREG)-1:0] cfg_idx,
  input  logic [AW-1:0]           cfg_base,
  input  logic [4:0]              cfg_size,
  input  logic [3:0]              cfg_perm,
  input  logic                    acc_req,
  input  logic [AW-1:0]           acc_addr,
  input  logic                    acc_write,
  input  logic                    acc_priv,
  input  logic                    acc_fetch,
  input  logic [4:0]              sr_mode,
  output logic                    abort,
  output logic                    abort_pf,
  output logic [4:0]              mode_inv
);
  localparam int SPAN = AW - MINLOG;

  logic [AW-1:0] base_q [NREG];
  logic [4:0]    size_q [NREG];
  logic [3:0]    perm_q [NREG];
  logic [NREG-1:0] hit, deny;
  logic          bad;

  assign mode_inv = ~sr_mode;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [AW-1:0] mask;
    assign mask = (int'(size_q[i]) >= SPAN) ? '0
                : ({AW{1'b1}} << (MINLOG + int'(size_q[i])));
    assign hit[i]  = perm_q[i][0] && ((acc_addr & mask) == (base_q[i] & mask));
    assign deny[i] = (perm_q[i][3] && !acc_priv)
                   || (perm_q[i][2] && !acc_fetch)
                   || (perm_q[i][1] && acc_write);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        size_q[i] <= '0;
        perm_q[i] <= '0;
      end else if (cfg_we && int'(cfg_idx) == i) begin
        base_q[i] <= cfg_base;
        size_q[i] <= cfg_size;
        perm_q[i] <= cfg_perm;
      end
    end
  end

  always_comb begin
    bad = 1'b1;
    for (int i = NREG - 1; i >= 0; i--)
      if (hit[i]) bad = deny[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort    <= 1'b0;
      abort_pf <= 1'b0;
    end else begin
      abort    <= acc_req && bad;
      abort_pf <= acc_req && bad && acc_fetch;
    end
  end
endmodule

// File: rtl/prot_check_sva.sv
module prot_check_sva (
  input logic clk,
  input logic rst_n,
  input logic acc_req,
  input logic acc_fetch,
  input logic abort,
  input logic abort_pf
);
  a_r5_idle_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> !abort);

  a_r9_pf_needs_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pf |-> abort);

  a_r9_pf_follows_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (abort_pf == $past(acc_fetch)));

  always @(negedge clk)
    if (!rst_n) a_r1_reset_quiet: assert (!abort && !abort_pf);
endmodule

bind prot_check prot_check_sva u_sva (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_fetch(acc_fetch),
  .abort(abort), .abort_pf(abort_pf)
);

// File: tb/tb_prot_check.sv
module tb_prot_check;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_idx = 0;
  logic [31:0] cfg_base = 0;
  logic [4:0] cfg_size = 0;
  logic [3:0] cfg_perm = 0;
  logic acc_req = 0, acc_write = 0, acc_priv = 0, acc_fetch = 0;
  logic [31:0] acc_addr = 0;
  logic [4:0] sr_mode = 0;
  logic abort, abort_pf;
  logic [4:0] mode_inv;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_base [8];
  logic [4:0]  m_size [8];
  logic [3:0]  m_perm [8];

  always #5 clk = ~clk;

  prot_check dut (.*);

  task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [31:0] a, input logic wr,
                                       input logic pv, input logic ft);
    for (int i = 0; i < 8; i++) begin
      logic h;
      if (m_size[i] >= 5'd20) h = 1'b1;
      else h = (a >> (12 + m_size[i])) == (m_base[i] >> (12 + m_size[i]));
      if (m_perm[i][0] && h) begin
        logic d;
        d = (m_perm[i][3] && !pv) || (m_perm[i][2] && !ft) || (m_perm[i][1] && wr);
        return {d, d && ft};
      end
    end
    return {1'b1, ft};
  endfunction

  task automatic cyc(input string tag, input logic we, input int idx,
                     input logic [31:0] b, input logic [4:0] k, input logic [3:0] p,
                     input logic rq, input logic [31:0] a, input logic wr,
                     input logic pv, input logic ft);
    logic [1:0] e;
    cfg_we = we; cfg_idx = 3'(idx); cfg_base = b; cfg_size = k; cfg_perm = p;
    acc_req = rq; acc_addr = a; acc_write = wr; acc_priv = pv; acc_fetch = ft;
    e = rq ? model(a, wr, pv, ft) : 2'b00;
    @(posedge clk);
    @(negedge clk);
    chk(tag, {4'b0, abort, abort_pf}, {4'b0, e});
    if (we) begin m_base[idx] = b; m_size[idx] = k; m_perm[idx] = p; end
    cfg_we = 0; acc_req = 0;
  endtask

  task automatic wr_reg(input int idx, input logic [31:0] b, input logic [4:0] k,
                        input logic [3:0] p);
    cyc("R2 cfg", 1, idx, b, k, p, 0, 0, 0, 0, 0);
  endtask

  task automatic acc(input string tag, input logic [31:0] a, input logic wr,
                     input logic pv, input logic ft);
    cyc(tag, 0, 0, 0, 0, 0, 1, a, wr, pv, ft);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) begin m_base[i] = 0; m_size[i] = 0; m_perm[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 reset", {4'b0, abort, abort_pf}, 6'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {4'b0, abort, abort_pf}, 6'b0);
    acc("R4 empty table aborts", 32'h1000, 0, 1, 1);
    acc("R4 empty table data", 32'h1000, 0, 1, 0);
    cyc("R5 idle no abort", 0, 0, 0, 0, 0, 0, 32'h1000, 1, 0, 0);
    // whole space open via clamped code
    wr_reg(7, 32'hdead_beef, 5'd31, 4'b0001);
    acc("R3 clamp whole space", 32'h8000_0000, 1, 0, 0);
    // R8 small read-only inside larger open region, priority
    wr_reg(1, 32'h0001_0000, 5'd4, 4'b0001);      // 64 KB open
    wr_reg(0, 32'h0001_2fff, 5'd0, 4'b0011);      // 4 KB read-only, low bits ignored
    acc("R8 read-only write", 32'h0001_2004, 1, 1, 0);
    acc("R8 read-only read", 32'h0001_2004, 0, 1, 0);
    acc("R4 outer region write", 32'h0001_3000, 1, 1, 0);
    // R4 swap order: open region at lower index wins
    wr_reg(0, 32'h0001_0000, 5'd4, 4'b0001);
    wr_reg(1, 32'h0001_2000, 5'd0, 4'b0011);
    acc("R4 lower index wins", 32'h0001_2004, 1, 1, 0);
    // R2 rewrite in the same cycle as access
    cyc("R2 same-edge uses old", 1, 0, 32'h0001_0000, 5'd4, 4'b0011,
        1, 32'h0001_0100, 1, 1, 0);
    acc("R2 new entry applies", 32'h0001_0100, 1, 1, 0);
    // R7 execute only
    wr_reg(2, 32'h0040_0000, 5'd2, 4'b0101);
    acc("R7 exec-only fetch ok", 32'h0040_1000, 0, 0, 1);
    acc("R7 exec-only data read", 32'h0040_1000, 0, 1, 0);
    acc("R7 exec-only data write", 32'h0040_1000, 1, 1, 0);
    // R6 privileged only, R9 class
    wr_reg(3, 32'h0080_0000, 5'd1, 4'b1001);
    acc("R6 user fetch denied R9", 32'h0080_0010, 0, 0, 1);
    acc("R6 user data denied R9", 32'h0080_0010, 0, 0, 0);
    acc("R6 privileged ok", 32'h0080_0010, 1, 1, 0);
    wr_reg(7, 0, 0, 0);
    acc("R4 no match aborts", 32'h7000_0000, 0, 1, 1);
    // R10 mode inverse
    for (int j = 0; j < 8; j++) begin
      sr_mode = 5'($urandom);
      #1;
      chk("R10 mode_inv", {1'b0, mode_inv}, {1'b0, ~sr_mode});
    end
    // random traffic
    for (int j = 0; j < 400; j++) begin
      int r;
      r = int'($urandom_range(0, 7));
      if ($urandom_range(0, 9) == 0)
        wr_reg(r, {8'h00, 4'($urandom), 20'h0} << 2, 5'($urandom_range(0, 6)),
               4'($urandom));
      else begin
        logic [31:0] a;
        a = m_base[r] + 32'($urandom_range(0, 32'h3_ffff));
        if ($urandom_range(0, 7) == 0) a = $urandom;
        if ($urandom_range(0, 5) == 0)
          cyc("R5 random idle", 0, 0, 0, 0, 0, 0, a, 1'($urandom), 1'($urandom), 1'($urandom));
        else
          acc("R3 R6 R7 R8 R9 random", a, 1'($urandom), 1'($urandom), 1'($urandom));
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule